// File: doc/BRIEF.md
# Receive Character Queue with Per-Entry Error Tags and Line Status

This block sits between a serial character receiver and a processor-facing register interface. Each character the receiver finishes arrives with three error tags: parity, framing and break. The block stores the character and its tags together, so that a tag shows up in the status byte only when its own character reaches the read side. The block returns the oldest character on a data port. It also assembles a read-only 32-bit status word: data ready, overrun, the head character's three tags, two transmitter-empty flags that pass straight through, and a summary bit that stays set while any stored character is tagged.

A mode input selects queue operation with a parameterised depth or single-holding-register operation. In queue mode an overrun discards the arriving character. In single-register mode the arriving character replaces the unread one. In both modes the overrun flag is sticky until the status word is read, and reading data does not clear it. The mode input is expected to stay static while characters are stored, and the bench changes it only across a reset.

Top module: `rx_line_status`

## Requirements
- R1: Status word bit 0 is data ready, 1 overrun, 2 parity tag, 3 framing tag, 4 break tag, 5 holding-register-empty input, 6 transmitter-empty input, 7 error summary; bits 31:8 are always zero.
- R2: After reset the queue is empty, bits 0 to 4 and 7 read 0, and `buf_data` reads 0; with both transmitter-empty inputs high the status word reads 0x60.
- R3: Characters are returned on `buf_data` in arrival order, and `buf_data` always shows the head character. A `buf_rd` pulse on an empty queue changes nothing.
- R4: Data ready is 1 from the cycle after a character enters an empty store and stays 1 until the read that empties the store.
- R5: Bits 2, 3 and 4 show the tags of the head character only. They change in the cycle after a `buf_rd` pulse removes that character.
- R6: Bit 7 is 1 while at least one stored character carries any tag, whether or not it is at the head. It returns to 0 in the cycle after the last tagged character is read out.
- R7: In queue mode, a character that arrives while the queue holds DEPTH entries, with no read in the same cycle, is discarded without changing the contents. Overrun reads 1 from the next cycle on.
- R8: A `stat_rd` pulse clears overrun from the following cycle on. `buf_rd` never clears overrun. If an overrun occurs in the same cycle as `stat_rd`, overrun stays set.
- R9: If a read and an arriving character coincide on a full store, the read is taken first. The new character is stored and no overrun is raised, in either mode.
- R10: In single-register mode the store holds one character. A new character arriving while one is unread replaces it, tags included, and sets overrun. Reading it clears data ready and its tags.
- R11: The queue depth is set by the DEPTH parameter (default 16). The summary count is kept consistent across pushes, pops and overwrites.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_mode | input | 1 | 1 = queue of DEPTH entries, 0 = single holding register |
| char_valid | input | 1 | One-cycle strobe: a received character is complete |
| char_data | input | 8 | Received character |
| char_perr | input | 1 | Parity tag of the arriving character |
| char_ferr | input | 1 | Framing tag of the arriving character |
| char_brk | input | 1 | Break tag of the arriving character |
| buf_rd | input | 1 | One-cycle strobe: remove the head character |
| buf_data | output | 8 | Head character (0 when empty) |
| stat_rd | input | 1 | One-cycle strobe: status word is being read |
| tx_hold_empty | input | 1 | Transmit holding stage empty, shown in bit 5 |
| tx_all_empty | input | 1 | Transmitter fully idle, shown in bit 6 |
| stat_word | output | 32 | Line status word |

## Verification
Several properties are checked on every cycle. The assertions confirm that the fill level stays within the active mode's capacity, that a discarded character leaves a full queue full, and that a pop from an empty store changes nothing. They also confirm that the summary count never exceeds the fill level, that a tagged head always has the summary set, and that the overrun flag sets and clears in the required cycle. The order of characters, which tags appear at the head after each read, the exact status byte values, and the overwrite behaviour in single-register mode can only be shown by the bench's directed scenarios against expected values.

// File: rtl/rls_pkg.sv
package rls_pkg;
  localparam int CHAR_W = 8;
  localparam int STAT_W = 32;

  // Status bit positions (fixed: software decodes them)
  localparam int ST_DR   = 0;
  localparam int ST_OVR  = 1;
  localparam int ST_PAR  = 2;
  localparam int ST_FRM  = 3;
  localparam int ST_BRK  = 4;
  localparam int ST_THRE = 5;
  localparam int ST_TEMT = 6;
  localparam int ST_SUM  = 7;

  typedef struct packed {
    logic              brk;
    logic              ferr;
    logic              perr;
    logic [CHAR_W-1:0] data;
  } rx_entry_t;

  function automatic logic entry_tagged(input rx_entry_t e);
    return e.brk | e.ferr | e.perr;
  endfunction
endpackage

// File: rtl/rls_store.sv
module rls_store
  import rls_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           fifo_mode,
  input  logic                           push_req,
  input  logic                           pop_req,
  input  rx_entry_t                      wr_entry,
  output rx_entry_t                      head_entry,
  output logic                           head_valid,
  output logic [$clog2(DEPTH+1)-1:0]     fill,
  output logic                           push_ok,
  output logic                           pop_ok,
  output logic                           ovr_evt,
  output logic                           ovr_write
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  function automatic logic [PW-1:0] ptr_step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  function automatic logic [CW-1:0] fill_step(input logic [CW-1:0] f,
                                              input logic inc, input logic dec);
    return f + CW'(inc) - CW'(dec);
  endfunction

  rx_entry_t     mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cap;
  logic          full;

  assign cap        = fifo_mode ? CW'(DEPTH) : CW'(1);
  assign full       = (fill >= cap);
  assign head_valid = (fill != '0);
  assign pop_ok     = pop_req && head_valid;
  assign push_ok    = push_req && (!full || pop_ok);
  assign ovr_evt    = push_req && full && !pop_ok;
  assign ovr_write  = ovr_evt && !fifo_mode;
  assign head_entry = head_valid ? mem[rd_ptr] : '0;

  always_ff @(posedge clk) begin
    if (push_ok)        mem[wr_ptr] <= wr_entry;
    else if (ovr_write) mem[rd_ptr] <= wr_entry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (push_ok) wr_ptr <= ptr_step(wr_ptr);
      if (pop_ok)  rd_ptr <= ptr_step(rd_ptr);
      fill <= fill_step(fill, push_ok, pop_ok);
    end
  end

  // R11: fill never exceeds the configured depth
  a_r11_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(DEPTH));
  // R10: single-register mode never holds more than one character
  a_r10_single_cap: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_mode |-> fill <= CW'(1));
  // R7: a discarded character leaves a full queue full
  a_r7_discard_keeps_full: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_evt && fifo_mode) |=> fill == CW'(DEPTH));
  // R3: a pop on an empty store does nothing
  a_r3_pop_empty_noop: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !head_valid && !push_req) |=> fill == '0);
  // R4: the read that empties the store drops data-ready
  a_r4_drain_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ok && fill == CW'(1) && !push_ok) |=> !head_valid);
  // R9: a coincident pop and push on a full store is not an overrun
  a_r9_pop_first: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ok && push_req) |-> (push_ok && !ovr_evt));
endmodule

// File: rtl/rls_errcnt.sv
module rls_errcnt #(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push_ok,
  input  logic                       pop_ok,
  input  logic                       ovr_write,
  input  logic                       in_tagged,
  input  logic                       head_tagged,
  input  logic [$clog2(DEPTH+1)-1:0] fill,
  output logic                       err_any
);
  localparam int CW = $clog2(DEPTH + 1);

  // Adds a tagged arrival, removes a tagged departure; an overwrite does both
  function automatic logic [CW-1:0] tag_count_next(
    input logic [CW-1:0] cnt, input logic add_ev, input logic add_tag,
    input logic rem_ev, input logic rem_tag);
    return cnt + CW'(add_ev & add_tag) - CW'(rem_ev & rem_tag);
  endfunction

  logic [CW-1:0] err_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_cnt <= '0;
    else err_cnt <= tag_count_next(err_cnt, push_ok | ovr_write, in_tagged,
                                   pop_ok | ovr_write, head_tagged);
  end

  assign err_any = (err_cnt != '0);

  // R11: summary count can never exceed the number of stored characters
  a_r11_cnt_le_fill: assert property (@(posedge clk) disable iff (!rst_n)
    err_cnt <= fill);
  // R6: a tagged head always implies the summary is set
  a_r6_head_in_summary: assert property (@(posedge clk) disable iff (!rst_n)
    (fill != '0 && head_tagged) |-> err_any);
endmodule

// File: rtl/rls_status.sv
module rls_status
  import rls_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ovr_evt,
  input  logic              stat_rd,
  input  logic              head_valid,
  input  rx_entry_t         head_entry,
  input  logic              err_any,
  input  logic              tx_hold_empty,
  input  logic              tx_all_empty,
  output logic [STAT_W-1:0] stat_word
);
  logic ovr_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovr_flag <= 1'b0;
    else if (ovr_evt) ovr_flag <= 1'b1;
    else if (stat_rd) ovr_flag <= 1'b0;
  end

  always_comb begin
    stat_word          = '0;
    stat_word[ST_DR]   = head_valid;
    stat_word[ST_OVR]  = ovr_flag;
    stat_word[ST_PAR]  = head_entry.perr;
    stat_word[ST_FRM]  = head_entry.ferr;
    stat_word[ST_BRK]  = head_entry.brk;
    stat_word[ST_THRE] = tx_hold_empty;
    stat_word[ST_TEMT] = tx_all_empty;
    stat_word[ST_SUM]  = err_any;
  end

  // R7: overrun is visible the cycle after the event
  a_r7_ovr_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> stat_word[ST_OVR]);
  // R8: a status read with no new overrun clears the flag next cycle
  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !ovr_evt) |=> !stat_word[ST_OVR]);
  // R8: without a status read the flag cannot fall
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_word[ST_OVR] && !stat_rd) |=> stat_word[ST_OVR]);
endmodule

// File: rtl/rx_line_status.sv
module rx_line_status
  import rls_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_mode,
  input  logic              char_valid,
  input  logic [CHAR_W-1:0] char_data,
  input  logic              char_perr,
  input  logic              char_ferr,
  input  logic              char_brk,
  input  logic              buf_rd,
  output logic [CHAR_W-1:0] buf_data,
  input  logic              stat_rd,
  input  logic              tx_hold_empty,
  input  logic              tx_all_empty,
  output logic [STAT_W-1:0] stat_word
);
  localparam int CW = $clog2(DEPTH + 1);

  rx_entry_t     in_entry, head_entry;
  logic          head_valid, push_ok, pop_ok, ovr_evt, ovr_write, err_any;
  logic [CW-1:0] fill;

  assign in_entry = '{brk: char_brk, ferr: char_ferr, perr: char_perr, data: char_data};
  assign buf_data = head_entry.data;

  rls_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode),
    .push_req(char_valid), .pop_req(buf_rd), .wr_entry(in_entry),
    .head_entry(head_entry), .head_valid(head_valid), .fill(fill),
    .push_ok(push_ok), .pop_ok(pop_ok), .ovr_evt(ovr_evt), .ovr_write(ovr_write)
  );

  rls_errcnt #(.DEPTH(DEPTH)) u_errcnt (
    .clk(clk), .rst_n(rst_n), .push_ok(push_ok), .pop_ok(pop_ok),
    .ovr_write(ovr_write), .in_tagged(entry_tagged(in_entry)),
    .head_tagged(entry_tagged(head_entry)), .fill(fill), .err_any(err_any)
  );

  rls_status u_status (
    .clk(clk), .rst_n(rst_n), .ovr_evt(ovr_evt), .stat_rd(stat_rd),
    .head_valid(head_valid), .head_entry(head_entry), .err_any(err_any),
    .tx_hold_empty(tx_hold_empty), .tx_all_empty(tx_all_empty),
    .stat_word(stat_word)
  );

  // R1: upper bits stay zero whatever the inputs
  a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    stat_word[STAT_W-1:8] == '0);
  // R10: an overwrite in single-register mode keeps exactly one character
  a_r10_overwrite_one: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_write |=> (head_valid && buf_data == $past(char_data)));
endmodule

// File: tb/test_rx_line_status.sv
`timescale 1ns/1ps
module test_rx_line_status;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fifo_mode = 1'b1;
  logic        char_valid = 1'b0;
  logic [7:0]  char_data = '0;
  logic        char_perr = 1'b0, char_ferr = 1'b0, char_brk = 1'b0;
  logic        buf_rd = 1'b0, stat_rd = 1'b0;
  logic        tx_hold_empty = 1'b1, tx_all_empty = 1'b1;
  logic [7:0]  buf_data;
  logic [31:0] stat_word;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  rx_line_status #(.DEPTH(DEPTH)) i_rx_line_status (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode),
    .char_valid(char_valid), .char_data(char_data),
    .char_perr(char_perr), .char_ferr(char_ferr), .char_brk(char_brk),
    .buf_rd(buf_rd), .buf_data(buf_data), .stat_rd(stat_rd),
    .tx_hold_empty(tx_hold_empty), .tx_all_empty(tx_all_empty),
    .stat_word(stat_word)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset(input logic mode);
    rst_n = 1'b0; fifo_mode = mode;
    char_valid = 0; buf_rd = 0; stat_rd = 0;
    tx_hold_empty = 1; tx_all_empty = 1;
    cyc(); cyc();
    rst_n = 1'b1;
    cyc();
  endtask

  task automatic push_c(input logic [7:0] d, input logic p, input logic f, input logic b);
    char_valid = 1; char_data = d; char_perr = p; char_ferr = f; char_brk = b;
    cyc();
    char_valid = 0; char_perr = 0; char_ferr = 0; char_brk = 0;
  endtask

  task automatic pop_c();
    buf_rd = 1; cyc(); buf_rd = 0;
  endtask

  task automatic fill_q();
    for (int i = 0; i < DEPTH; i++) push_c(8'(i), 0, 0, 0);
  endtask

  task automatic t_reset();
    do_reset(1'b1);
    chk("R2 status after reset", stat_word, 32'h60);
    chk("R2 data after reset", {24'h0, buf_data}, 32'h0);
  endtask

  task automatic t_passthrough();
    tx_hold_empty = 0; tx_all_empty = 1; #1;
    chk("R1 hold-empty low", stat_word, 32'h40);
    tx_hold_empty = 1; tx_all_empty = 0; #1;
    chk("R1 all-empty low", stat_word, 32'h20);
    tx_hold_empty = 1; tx_all_empty = 1; #1;
  endtask

  task automatic t_order();
    do_reset(1'b1);
    push_c(8'hA1, 0, 0, 0);
    chk("R4 ready after first push", stat_word, 32'h61);
    push_c(8'hB2, 0, 0, 0);
    push_c(8'hC3, 0, 0, 0);
    chk("R3 head first", {24'h0, buf_data}, 32'hA1);
    pop_c();
    chk("R3 head second", {24'h0, buf_data}, 32'hB2);
    chk("R4 ready stays", stat_word, 32'h61);
    pop_c();
    chk("R3 head third", {24'h0, buf_data}, 32'hC3);
    pop_c();
    chk("R4 ready clears when empty", stat_word, 32'h60);
    pop_c();
    chk("R3 pop on empty no effect", stat_word, 32'h60);
    push_c(8'h55, 0, 0, 0);
    chk("R3 pointer intact after empty pop", {24'h0, buf_data}, 32'h55);
  endtask

  task automatic t_tags();
    do_reset(1'b1);
    push_c(8'h01, 1, 0, 0);
    push_c(8'h02, 0, 0, 0);
    push_c(8'h03, 0, 1, 1);
    chk("R5 parity tag at head", stat_word, 32'hE5);
    pop_c();
    chk("R6 summary with clean head", stat_word, 32'hE1);
    pop_c();
    chk("R5 framing and break at head", stat_word, 32'hF9);
    pop_c();
    chk("R6 summary clears after last tagged", stat_word, 32'h60);
    push_c(8'h10, 0, 0, 0);
    push_c(8'h11, 0, 0, 1);
    chk("R6 tagged entry behind clean head", stat_word, 32'hE1);
    pop_c();
    chk("R5 break tag reaches head", stat_word, 32'hF1);
    pop_c();
    chk("R6 summary clear after drain", stat_word, 32'h60);
  endtask

  task automatic t_ovr_fifo();
    do_reset(1'b1);
    fill_q();
    chk("R11 full queue no overrun", stat_word, 32'h61);
    push_c(8'hEE, 1, 0, 0);
    chk("R7 overrun set, tag discarded", stat_word, 32'h63);
    for (int i = 0; i < DEPTH; i++) begin
      chk("R7 contents unchanged", {24'h0, buf_data}, 32'(i));
      pop_c();
    end
    chk("R8 data reads do not clear overrun", stat_word, 32'h62);
    stat_rd = 1; #1;
    chk("R8 flag still visible in read cycle", stat_word, 32'h62);
    cyc(); stat_rd = 0;
    chk("R8 cleared after status read", stat_word, 32'h60);
  endtask

  task automatic t_same_cycle();
    do_reset(1'b1);
    fill_q();
    char_valid = 1; char_data = 8'h77; buf_rd = 1;
    cyc();
    char_valid = 0; buf_rd = 0;
    chk("R9 pop first, no overrun", stat_word, 32'h61);
    for (int i = 1; i < DEPTH; i++) pop_c();
    chk("R9 coincident char stored last", {24'h0, buf_data}, 32'h77);
  endtask

  task automatic t_ovr_race();
    do_reset(1'b1);
    fill_q();
    char_valid = 1; char_data = 8'h99; stat_rd = 1;
    cyc();
    char_valid = 0; stat_rd = 0;
    chk("R8 overrun wins over same-cycle read", stat_word, 32'h63);
    stat_rd = 1; cyc(); stat_rd = 0;
    chk("R8 later read clears", stat_word, 32'h61);
  endtask

  task automatic t_single();
    do_reset(1'b0);
    push_c(8'h11, 1, 0, 0);
    chk("R10 single holds tagged char", stat_word, 32'hE5);
    push_c(8'h22, 0, 0, 0);
    chk("R10 overwrite data", {24'h0, buf_data}, 32'h22);
    chk("R10 overwrite clears old tags, sets overrun", stat_word, 32'h63);
    push_c(8'h33, 0, 1, 0);
    chk("R10 overwrite with framing tag", stat_word, 32'hEB);
    pop_c();
    chk("R10 read clears ready and tags", stat_word, 32'h62);
    stat_rd = 1; cyc(); stat_rd = 0;
    chk("R8 single-mode status read", stat_word, 32'h60);
    push_c(8'h44, 0, 0, 0);
    char_valid = 1; char_data = 8'h55; buf_rd = 1;
    cyc();
    char_valid = 0; buf_rd = 0;
    chk("R9 single pop-first status", stat_word, 32'h61);
    chk("R9 single pop-first data", {24'h0, buf_data}, 32'h55);
  endtask

  initial begin
    t_reset();
    t_passthrough();
    t_order();
    t_tags();
    t_ovr_fifo();
    t_same_cycle();
    t_ovr_race();
    t_single();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #800000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule